// File: doc/BRIEF.md
# Signed Bounds Check and Trap Unit

This block evaluates one signed range check per request and reports the condition flags the check produces, which of those flags the check is allowed to write, and whether the check asks for a trap. Two forms are supported. The single-bound form tests a value against an upper limit, with zero serving as the implied lower limit. The pair form tests a value against an explicit lower and upper limit. The pair form can also run as a plain compare, setting flags with no trap.

A lower limit that sits above the upper limit describes a range that wraps around. In that case the carry flag means "strictly between the upper and the lower limit" rather than "outside the range". Operands may be byte, word or long sized. Narrow operands are sign-extended to the full width before any comparison.

The block accepts one request per cycle and presents the result one clock later. A three-state result register tracks whether the presented result is idle (ST_IDLE), from the single-bound form (ST_SINGLE) or from the pair form (ST_PAIR). From any state, the next state is ST_SINGLE on a valid single-bound request, ST_PAIR on a valid pair request, and ST_IDLE when no request is presented. Reset enters ST_IDLE.

Top module: `bchk_trap_unit`

## Requirements
- R1: In the single-bound form (req_form=0), flag_n is 1 exactly when the sign-extended value is negative.
- R2: In the single-bound form with a sign-extended upper limit of zero or more, flag_c is 1 when the value is negative or greater than the upper limit.
- R3: In the single-bound form with a negative upper limit, flag_c is 1 only when the value is both greater than the upper limit and negative.
- R4: In the single-bound form, trap_req is 1 when the value is negative or greater than the upper limit, regardless of req_trap_en. upd_n=1, upd_c=1, upd_z=0 and flag_z=0. req_lower has no effect on any output.
- R5: In the pair form (req_form=1), flag_z is 1 when the value equals the lower limit or the upper limit, and 0 otherwise.
- R6: In the pair form with lower at most upper, flag_c is 1 when the value is below lower or above upper.
- R7: In the pair form with lower greater than upper, flag_c is 1 only when the value is above upper and also below lower.
- R8: In the pair form, trap_req equals flag_c AND req_trap_en. upd_z=1, upd_c=1, upd_n=0 and flag_n=0.
- R9: req_size selects the operand size for all three operands: 2'b00 uses bits 7:0 and 2'b01 uses bits 15:0, each sign-extended. 2'b10 and 2'b11 use the full 32 bits. Bits above the selected size are ignored.
- R10: Results appear on the outputs one clock after the request edge, with rsp_valid=1. A cycle with req_valid=0 yields rsp_valid=0, with every flag, update enable and trap_req at 0 on the next cycle. Back-to-back requests of different forms are each reported in their own cycle.
- R11: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_form | input | 1 | 0 = single-bound form, 1 = pair form |
| req_size | input | 2 | Operand size: 00 byte, 01 word, 1x long |
| req_trap_en | input | 1 | Pair form: allow trap request |
| req_value | input | 32 | Value under test |
| req_lower | input | 32 | Lower limit (pair form only) |
| req_upper | input | 32 | Upper limit |
| rsp_valid | output | 1 | Result presented this cycle |
| flag_n | output | 1 | Negative flag result |
| flag_z | output | 1 | Zero (bound hit) flag result |
| flag_c | output | 1 | Carry (out of range) flag result |
| upd_n | output | 1 | flag_n is to be written |
| upd_z | output | 1 | flag_z is to be written |
| upd_c | output | 1 | flag_c is to be written |
| trap_req | output | 1 | Trap requested |

## Verification
In the pair form, a bound hit and a trap request can both be reachable in the same cycle. The bench drives a value equal to one limit of a wrapped range while traps are enabled. It expects flag_z set, flag_c clear and no trap.

In the single-bound form, a negative upper limit lets the carry flag and the trap diverge in the same result. The bench drives values above, below and between zero and the limit. For each value it compares flag_c and trap_req separately against a model built from the requirements.

Forms are also alternated on consecutive cycles, so the update enables must switch with each result.

// File: rtl/bchk_pkg.sv
package bchk_pkg;
    localparam int BCHK_W = 32;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_WORD = 2'b01;

    typedef enum logic {
        FORM_SINGLE = 1'b0,
        FORM_PAIR   = 1'b1
    } bchk_form_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SINGLE = 2'd1,
        ST_PAIR   = 2'd2
    } bchk_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic trap;
    } bchk_res_t;
endpackage

// File: rtl/bchk_sext.sv
module bchk_sext
    import bchk_pkg::*;
#(
    parameter int DATA_W = BCHK_W
) (
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    always_comb begin
        unique case (size_i)
            SZ_BYTE: data_o = {{(DATA_W-BYTE_W){data_i[BYTE_W-1]}}, data_i[BYTE_W-1:0]};
            SZ_WORD: data_o = {{(DATA_W-WORD_W){data_i[WORD_W-1]}}, data_i[WORD_W-1:0]};
            default: data_o = data_i;
        endcase
    end
endmodule

// File: rtl/bchk_eval.sv
module bchk_eval
    import bchk_pkg::*;
#(
    parameter int DATA_W = BCHK_W
) (
    input  bchk_form_e               form_i,
    input  logic                     trap_en_i,
    input  logic signed [DATA_W-1:0] value_i,
    input  logic signed [DATA_W-1:0] lower_i,
    input  logic signed [DATA_W-1:0] upper_i,
    output bchk_res_t                res_o
);
    logic signed [DATA_W-1:0] lo_eff;
    logic below, above, wrapped, out_c;

    always_comb begin
        lo_eff  = (form_i == FORM_PAIR) ? lower_i : '0;
        below   = value_i < lo_eff;
        above   = value_i > upper_i;
        wrapped = lo_eff > upper_i;
        out_c   = wrapped ? (below && above) : (below || above);

        res_o.n = value_i[DATA_W-1];
        res_o.c = out_c;
        if (form_i == FORM_PAIR) begin
            res_o.z    = (value_i == lo_eff) || (value_i == upper_i);
            res_o.trap = out_c && trap_en_i;
        end else begin
            res_o.z    = 1'b0;
            res_o.trap = below || above;
        end
    end
endmodule

// File: rtl/bchk_trap_unit.sv
module bchk_trap_unit
    import bchk_pkg::*;
#(
    parameter int DATA_W = BCHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_form,
    input  logic [1:0]        req_size,
    input  logic              req_trap_en,
    input  logic [DATA_W-1:0] req_value,
    input  logic [DATA_W-1:0] req_lower,
    input  logic [DATA_W-1:0] req_upper,
    output logic              rsp_valid,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              upd_n,
    output logic              upd_z,
    output logic              upd_c,
    output logic              trap_req
);
    localparam int NUM_OPS = 3;
    localparam int OP_VAL  = 0;
    localparam int OP_LO   = 1;
    localparam int OP_HI   = 2;

    logic [DATA_W-1:0] raw_ops [NUM_OPS];
    logic [DATA_W-1:0] ext_ops [NUM_OPS];
    bchk_res_t   eval_res, res_q;
    bchk_state_e state, state_nxt;
    logic        value_sign;

    assign raw_ops[OP_VAL] = req_value;
    assign raw_ops[OP_LO]  = req_lower;
    assign raw_ops[OP_HI]  = req_upper;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_sext
        bchk_sext #(.DATA_W(DATA_W)) u_sext (
            .size_i (req_size),
            .data_i (raw_ops[g]),
            .data_o (ext_ops[g])
        );
    end

    assign value_sign = ext_ops[OP_VAL][DATA_W-1];

    bchk_eval #(.DATA_W(DATA_W)) u_eval (
        .form_i    (bchk_form_e'(req_form)),
        .trap_en_i (req_trap_en),
        .value_i   (ext_ops[OP_VAL]),
        .lower_i   (ext_ops[OP_LO]),
        .upper_i   (ext_ops[OP_HI]),
        .res_o     (eval_res)
    );

    // next-state selection
    always_comb begin
        if (!req_valid) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (bchk_form_e'(req_form))
                FORM_PAIR:   state_nxt = ST_PAIR;
                FORM_SINGLE: state_nxt = ST_SINGLE;
                default:     state_nxt = ST_IDLE;
            endcase
        end
    end

    // state and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            res_q <= '0;
        end else begin
            state <= state_nxt;
            if (req_valid) begin
                res_q <= eval_res;
            end
        end
    end

    // outputs per state
    always_comb begin
        rsp_valid = 1'b0;
        flag_n    = 1'b0;
        flag_z    = 1'b0;
        flag_c    = 1'b0;
        upd_n     = 1'b0;
        upd_z     = 1'b0;
        upd_c     = 1'b0;
        trap_req  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SINGLE: begin
                rsp_valid = 1'b1;
                upd_n     = 1'b1;
                upd_c     = 1'b1;
                flag_n    = res_q.n;
                flag_c    = res_q.c;
                trap_req  = res_q.trap;
            end
            ST_PAIR: begin
                rsp_valid = 1'b1;
                upd_z     = 1'b1;
                upd_c     = 1'b1;
                flag_z    = res_q.z;
                flag_c    = res_q.c;
                trap_req  = res_q.trap;
            end
            default: ;
        endcase
    end

    // assertions
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (rsp_valid == $past(req_valid)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(trap_req || upd_n || upd_z || upd_c || flag_n || flag_z || flag_c));

    p_pair_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(req_valid && req_form)) |-> (!upd_n && upd_z && upd_c && !flag_n));

    p_pair_trap_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(req_valid && req_form && !req_trap_en)) |-> !trap_req);

    p_single_n_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(req_valid && !req_form)) |-> (flag_n == $past(value_sign)));

    p_single_neg_traps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(req_valid && !req_form && value_sign)) |-> (trap_req && !upd_z));

    p_bound_hit_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_z && flag_z) |-> (!flag_c && !trap_req));
endmodule

// File: tb/tb_bchk_trap_unit.sv
module tb_bchk_trap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_form = 1'b0;
    logic [1:0]  req_size = 2'b10;
    logic        req_trap_en = 1'b0;
    logic [31:0] req_value = '0;
    logic [31:0] req_lower = '0;
    logic [31:0] req_upper = '0;
    logic rsp_valid, flag_n, flag_z, flag_c, upd_n, upd_z, upd_c, trap_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bchk_trap_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_form(req_form),
        .req_size(req_size), .req_trap_en(req_trap_en), .req_value(req_value),
        .req_lower(req_lower), .req_upper(req_upper), .rsp_valid(rsp_valid),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .upd_n(upd_n),
        .upd_z(upd_z), .upd_c(upd_c), .trap_req(trap_req)
    );

    function automatic logic signed [31:0] sx(input logic [1:0] sz, input logic [31:0] d);
        case (sz)
            2'b00:   return {{24{d[7]}}, d[7:0]};
            2'b01:   return {{16{d[15]}}, d[15:0]};
            default: return d;
        endcase
    endfunction

    // {rsp_valid, n, z, c, upd_n, upd_z, upd_c, trap}
    function automatic logic [7:0] model(input logic form, input logic [1:0] sz,
                                         input logic te, input logic [31:0] v,
                                         input logic [31:0] lo, input logic [31:0] hi);
        logic signed [31:0] sv, sl, su;
        logic n, z, c, t;
        sv = sx(sz, v); sl = sx(sz, lo); su = sx(sz, hi);
        if (!form) begin
            n = sv < 0;
            z = 1'b0;
            c = (su >= 0) ? (sv < 0 || sv > su) : (sv > su && sv < 0);
            t = sv < 0 || sv > su;
            return {1'b1, n, z, c, 1'b1, 1'b0, 1'b1, t};
        end
        n = 1'b0;
        z = (sv == sl) || (sv == su);
        c = (sl <= su) ? (sv < sl || sv > su) : (sv > su && sv < sl);
        t = c && te;
        return {1'b1, n, z, c, 1'b0, 1'b1, 1'b1, t};
    endfunction

    function automatic logic [7:0] seen();
        return {rsp_valid, flag_n, flag_z, flag_c, upd_n, upd_z, upd_c, trap_req};
    endfunction

    task automatic check_vec(input string tag, input logic [7:0] exp_v);
        checks++;
        if (seen() !== exp_v) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b (v n z c un uz uc trap)", tag, seen(), exp_v);
        end
    endtask

    // called at a negedge; result checked at the following negedge
    task automatic issue(input string tag, input logic form, input logic [1:0] sz,
                         input logic te, input logic [31:0] v,
                         input logic [31:0] lo, input logic [31:0] hi);
        req_valid = 1'b1; req_form = form; req_size = sz; req_trap_en = te;
        req_value = v; req_lower = lo; req_upper = hi;
        @(negedge clk);
        check_vec(tag, model(form, sz, te, v, lo, hi));
    endtask

    task automatic idle(input string tag);
        req_valid = 1'b0;
        req_value = 32'hFFFF_FFFF;
        @(negedge clk);
        check_vec(tag, 8'h00);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check_vec("R11 reset outputs", 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_single_sign;
        issue("R1 negative value", 1'b0, 2'b10, 1'b0, -32'sd5, 32'd0, 32'd10);
        issue("R1 positive value", 1'b0, 2'b10, 1'b0, 32'd3, 32'd0, 32'd10);
        idle("R10 idle after single");
    endtask

    task automatic t_single_upper;
        issue("R2 above upper", 1'b0, 2'b10, 1'b0, 32'd11, 32'd0, 32'd10);
        issue("R2 at upper", 1'b0, 2'b10, 1'b0, 32'd10, 32'd0, 32'd10);
        issue("R2 zero value", 1'b0, 2'b10, 1'b0, 32'd0, 32'd0, 32'd0);
        idle("R10 idle");
    endtask

    task automatic t_single_neg_upper;
        issue("R3 between upper and zero", 1'b0, 2'b10, 1'b0, -32'sd3, 32'd0, -32'sd10);
        issue("R3 positive value traps without C", 1'b0, 2'b10, 1'b0, 32'd5, 32'd0, -32'sd10);
        issue("R3 below upper traps without C", 1'b0, 2'b10, 1'b0, -32'sd20, 32'd0, -32'sd10);
        idle("R10 idle");
    endtask

    task automatic t_single_lower_ignored;
        issue("R4 lower=+100 ignored", 1'b0, 2'b10, 1'b1, 32'd5, 32'd100, 32'd10);
        issue("R4 lower=-100 ignored", 1'b0, 2'b10, 1'b0, 32'd5, -32'sd100, 32'd10);
        issue("R4 trap regardless of enable", 1'b0, 2'b10, 1'b0, 32'd50, 32'd60, 32'd10);
        idle("R10 idle");
    endtask

    task automatic t_pair_equal;
        issue("R5 equals lower", 1'b1, 2'b10, 1'b1, -32'sd4, -32'sd4, 32'd8);
        issue("R5 equals upper", 1'b1, 2'b10, 1'b1, 32'd8, -32'sd4, 32'd8);
        issue("R5 inside no hit", 1'b1, 2'b10, 1'b1, 32'd0, -32'sd4, 32'd8);
        idle("R10 idle");
    endtask

    task automatic t_pair_normal;
        issue("R6 above upper", 1'b1, 2'b10, 1'b1, 32'd9, -32'sd4, 32'd8);
        issue("R6 below lower", 1'b1, 2'b10, 1'b1, -32'sd5, -32'sd4, 32'd8);
        idle("R10 idle");
    endtask

    task automatic t_pair_wrapped;
        issue("R7 between limits", 1'b1, 2'b10, 1'b1, 32'd0, 32'd10, -32'sd10);
        issue("R7 above lower", 1'b1, 2'b10, 1'b1, 32'd20, 32'd10, -32'sd10);
        issue("R7 below upper", 1'b1, 2'b10, 1'b1, -32'sd20, 32'd10, -32'sd10);
        issue("R7 hit lower no trap", 1'b1, 2'b10, 1'b1, 32'd10, 32'd10, -32'sd10);
        idle("R10 idle");
    endtask

    task automatic t_pair_compare_only;
        issue("R8 out of range trap disabled", 1'b1, 2'b10, 1'b0, 32'd9, -32'sd4, 32'd8);
        issue("R8 out of range trap enabled", 1'b1, 2'b10, 1'b1, 32'd9, -32'sd4, 32'd8);
        idle("R10 idle");
    endtask

    task automatic t_sizes;
        issue("R9 byte value negative", 1'b0, 2'b00, 1'b0, 32'h0000_00F0, 32'd0, 32'h0000_0010);
        issue("R9 word lower hit", 1'b1, 2'b01, 1'b1, 32'h1234_8000, 32'hFFFF_8000, 32'h0000_7FFF);
        issue("R9 byte upper bits ignored", 1'b1, 2'b00, 1'b1, 32'hAB00_0005, 32'h7700_0001, 32'h5500_0009);
        issue("R9 long 0x80 positive", 1'b0, 2'b10, 1'b0, 32'h0000_0080, 32'd0, 32'h0000_0010);
        issue("R9 size 11 is long", 1'b0, 2'b11, 1'b0, 32'h0000_0080, 32'd0, 32'h0000_00FF);
        idle("R10 idle");
    endtask

    task automatic t_back_to_back;
        issue("R10 single then", 1'b0, 2'b10, 1'b0, 32'd11, 32'd0, 32'd10);
        issue("R10 pair next cycle", 1'b1, 2'b10, 1'b1, 32'd3, 32'd3, 32'd9);
        issue("R10 single again", 1'b0, 2'b10, 1'b0, -32'sd1, 32'd0, 32'd10);
        idle("R10 idle after burst");
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single_sign();
        t_single_upper();
        t_single_neg_upper();
        t_single_lower_ignored();
        t_pair_equal();
        t_pair_normal();
        t_pair_wrapped();
        t_pair_compare_only();
        t_sizes();
        t_back_to_back();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule